// File: doc/BRIEF.md
# Teletext Request Window Generator

This block produces the strobe with which a video encoder requests teletext bits from an external data source. It watches the current line number and field parity. From a programmed start/end pair per field it decides whether the line belongs to the teletext insertion window. The line-to-register offsets differ between 525-line systems and all other systems, and the start and end registers use different offsets. A per-line disable mask can then remove individual lines from the window.

Inside the window the request output follows one of two protocols. In the bit-by-bit protocol, every rising edge of the request asks for one bit, paced by a bit-clock enable. In the burst protocol, the request goes high at the start of a window line and stays high until a standard-dependent number of bits has been clocked. The start/end pairs come up at strap-dependent defaults after reset and are replaced as a set by a load strobe.

Top module: `ttx_req_gen`

## Requirements
- R1: With `sys_525`=1, a line is in the window when start+4 <= line <= end+3, using the pair of the current field.
- R2: With `sys_525`=0, a line is in the window when start+1 <= line <= end.
- R3: After reset, and until the first `cfg_load`, both fields use start=04h and end=16h if `strap_525`=0, and start=05h and end=10h if `strap_525`=1.
- R4: `cfg_load`=1 captures all four register inputs at the clock edge. `field_even`=0 selects the odd pair and `field_even`=1 selects the even pair.
- R5: Mask bit k (k = 0..19) removes line 5+k from the window. A set mask bit for a line outside the start/end window leaves `in_win` at 0 and has no other effect.
- R6: With `old_proto`=0, `req` is high for exactly the one cycle after each cycle in which `bit_en`=1 and the line is in the window. Outside the window `req` stays low.
- R7: With `old_proto`=1, a change of `line_num` to a window line raises `req` one cycle later. `req` then stays high until the 360th `bit_en`, for 625-line teletext with `sys_525`=0 and `ws60_sel`=0.
- R8: The burst length is 288 bits with `sys_525`=1 and `ws60_sel`=0, and 296 bits with `ws60_sel`=1.
- R9: `req` and `in_win` are registered, updating one clock after their inputs, and both are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_525 | input | 1 | Static strap that selects the reset defaults |
| line_num | input | 10 | Current line number within the field |
| field_even | input | 1 | 1 for the even field |
| sys_525 | input | 1 | 1 for 525-line / 60 Hz systems |
| ws60_sel | input | 1 | 1 selects 60 Hz world-standard teletext |
| old_proto | input | 1 | 1 selects the burst request protocol |
| bit_en | input | 1 | Bit-clock enable, one cycle per teletext bit |
| cfg_load | input | 1 | Load strobe for the four start/end values |
| odd_start_in | input | 8 | Odd field start value |
| odd_end_in | input | 8 | Odd field end value |
| even_start_in | input | 8 | Even field start value |
| even_end_in | input | 8 | Even field end value |
| line_mask | input | 20 | Per-line disable mask for lines 5 to 24 |
| req | output | 1 | Teletext bit request |
| in_win | output | 1 | Current line is an active teletext line |

## Verification
The assertions assume that `bit_en` is never high on two consecutive cycles. Under that assumption, each bit gives a separate rising edge of `req` in the bit-by-bit protocol. They also assume that the mode and line do not change inside the cycles over which a property looks back. The stimulus drives `bit_en` as single-cycle pulses with at least one idle cycle between them. Configuration, mode and field changes are made only between bursts. Every burst starts from a line outside the window.

// File: rtl/ttx_req_pkg.sv
package ttx_req_pkg;

  typedef enum logic [1:0] {
    STD_EURO  = 2'd0,
    STD_NABTS = 2'd1,
    STD_WST60 = 2'd2
  } ttx_std_e;

  function automatic ttx_std_e pick_std(input logic ws60, input logic m525);
    if (ws60)      return STD_WST60;
    else if (m525) return STD_NABTS;
    else           return STD_EURO;
  endfunction

endpackage

// File: rtl/ttx_cfg_regs.sv
module ttx_cfg_regs #(
  parameter int REG_W  = 8,
  parameter int D625_S = 4,
  parameter int D625_E = 22,
  parameter int D525_S = 5,
  parameter int D525_E = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_525,
  input  logic             cfg_load,
  input  logic [REG_W-1:0] odd_s_in,
  input  logic [REG_W-1:0] odd_e_in,
  input  logic [REG_W-1:0] even_s_in,
  input  logic [REG_W-1:0] even_e_in,
  output logic [REG_W-1:0] odd_s,
  output logic [REG_W-1:0] odd_e,
  output logic [REG_W-1:0] even_s,
  output logic [REG_W-1:0] even_e
);

  logic             use_def_q, use_def_n;
  logic [REG_W-1:0] os_q, oe_q, es_q, ee_q;
  logic [REG_W-1:0] os_n, oe_n, es_n, ee_n;
  logic [REG_W-1:0] def_s, def_e;

  always_comb begin
    use_def_n = use_def_q;
    os_n = os_q;
    oe_n = oe_q;
    es_n = es_q;
    ee_n = ee_q;
    if (cfg_load) begin
      use_def_n = 1'b0;
      os_n = odd_s_in;
      oe_n = odd_e_in;
      es_n = even_s_in;
      ee_n = even_e_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_def_q <= 1'b1;
      os_q <= '0;
      oe_q <= '0;
      es_q <= '0;
      ee_q <= '0;
    end else begin
      use_def_q <= use_def_n;
      os_q <= os_n;
      oe_q <= oe_n;
      es_q <= es_n;
      ee_q <= ee_n;
    end
  end

  // Defaults follow the static strap until software loads real values.
  always_comb begin
    def_s  = strap_525 ? REG_W'(D525_S) : REG_W'(D625_S);
    def_e  = strap_525 ? REG_W'(D525_E) : REG_W'(D625_E);
    odd_s  = use_def_q ? def_s : os_q;
    odd_e  = use_def_q ? def_e : oe_q;
    even_s = use_def_q ? def_s : es_q;
    even_e = use_def_q ? def_e : ee_q;
  end

endmodule

// File: rtl/ttx_line_window.sv
module ttx_line_window #(
  parameter int LINE_W    = 10,
  parameter int REG_W     = 8,
  parameter int MASK_W    = 20,
  parameter int MASK_BASE = 5
) (
  input  logic [LINE_W-1:0] line_num,
  input  logic              sys_525,
  input  logic [REG_W-1:0]  start_r,
  input  logic [REG_W-1:0]  end_r,
  input  logic [MASK_W-1:0] line_mask,
  output logic              in_win_c
);

  localparam int EXT_W = ((LINE_W > REG_W) ? LINE_W : REG_W) + 1;

  logic [EXT_W-1:0]  first_l, last_l, line_x;
  logic [MASK_W-1:0] hit_vec;
  logic              in_range, masked;

  // Start and end registers carry different offsets per system.
  always_comb begin
    line_x   = EXT_W'(line_num);
    first_l  = EXT_W'(start_r) + (sys_525 ? EXT_W'(4) : EXT_W'(1));
    last_l   = EXT_W'(end_r)   + (sys_525 ? EXT_W'(3) : EXT_W'(0));
    in_range = (line_x >= first_l) && (line_x <= last_l);
  end

  for (genvar k = 0; k < MASK_W; k++) begin : g_mask
    assign hit_vec[k] = line_mask[k] && (line_num == LINE_W'(MASK_BASE + k));
  end

  assign masked   = |hit_vec;
  assign in_win_c = in_range && !masked;

endmodule

// File: rtl/ttx_req_proto.sv
module ttx_req_proto
  import ttx_req_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int CNT_W     = 9,
  parameter int LEN_EURO  = 360,
  parameter int LEN_NABTS = 288,
  parameter int LEN_WST60 = 296
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic              in_win_c,
  input  logic              bit_en,
  input  logic              old_proto,
  input  logic              ws60_sel,
  input  logic              sys_525,
  output logic              req,
  output logic              in_win
);

  ttx_std_e          std_sel;
  logic [CNT_W-1:0]  burst_len;
  logic [LINE_W-1:0] line_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              req_q, req_n;
  logic              win_q;
  logic              line_chg;

  always_comb begin
    std_sel = pick_std(ws60_sel, sys_525);
    unique case (std_sel)
      STD_NABTS: burst_len = CNT_W'(LEN_NABTS);
      STD_WST60: burst_len = CNT_W'(LEN_WST60);
      default:   burst_len = CNT_W'(LEN_EURO);
    endcase
  end

  always_comb begin
    line_chg = (line_num != line_q);
    cnt_n    = cnt_q;
    if (line_chg) begin
      cnt_n = in_win_c ? burst_len : '0;
    end else if (bit_en && (cnt_q != '0)) begin
      cnt_n = cnt_q - CNT_W'(1);
    end
    req_n = old_proto ? (cnt_n != '0) : (in_win_c && bit_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      cnt_q  <= '0;
      req_q  <= 1'b0;
      win_q  <= 1'b0;
    end else begin
      line_q <= line_num;
      cnt_q  <= cnt_n;
      req_q  <= req_n;
      win_q  <= in_win_c;
    end
  end

  assign req    = req_q;
  assign in_win = win_q;

endmodule

// File: rtl/ttx_req_gen.sv
module ttx_req_gen #(
  parameter int LINE_W    = 10,
  parameter int REG_W     = 8,
  parameter int MASK_W    = 20,
  parameter int MASK_BASE = 5,
  parameter int LEN_EURO  = 360,
  parameter int LEN_NABTS = 288,
  parameter int LEN_WST60 = 296
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_525,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_even,
  input  logic              sys_525,
  input  logic              ws60_sel,
  input  logic              old_proto,
  input  logic              bit_en,
  input  logic              cfg_load,
  input  logic [REG_W-1:0]  odd_start_in,
  input  logic [REG_W-1:0]  odd_end_in,
  input  logic [REG_W-1:0]  even_start_in,
  input  logic [REG_W-1:0]  even_end_in,
  input  logic [MASK_W-1:0] line_mask,
  output logic              req,
  output logic              in_win
);

  localparam int MAX_A   = (LEN_EURO > LEN_NABTS) ? LEN_EURO : LEN_NABTS;
  localparam int MAX_LEN = (MAX_A > LEN_WST60) ? MAX_A : LEN_WST60;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             rst_meta, rst_s;
  logic [REG_W-1:0] odd_s, odd_e, even_s, even_e;
  logic [REG_W-1:0] cur_s, cur_e;
  logic             in_win_c;

  // Asserts asynchronously, releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  ttx_cfg_regs #(
    .REG_W(REG_W), .D625_S(4), .D625_E(22), .D525_S(5), .D525_E(16)
  ) u_regs (
    .clk(clk), .rst_n(rst_s), .strap_525(strap_525), .cfg_load(cfg_load),
    .odd_s_in(odd_start_in), .odd_e_in(odd_end_in),
    .even_s_in(even_start_in), .even_e_in(even_end_in),
    .odd_s(odd_s), .odd_e(odd_e), .even_s(even_s), .even_e(even_e)
  );

  assign cur_s = field_even ? even_s : odd_s;
  assign cur_e = field_even ? even_e : odd_e;

  ttx_line_window #(
    .LINE_W(LINE_W), .REG_W(REG_W), .MASK_W(MASK_W), .MASK_BASE(MASK_BASE)
  ) u_win (
    .line_num(line_num), .sys_525(sys_525), .start_r(cur_s), .end_r(cur_e),
    .line_mask(line_mask), .in_win_c(in_win_c)
  );

  ttx_req_proto #(
    .LINE_W(LINE_W), .CNT_W(CNT_W),
    .LEN_EURO(LEN_EURO), .LEN_NABTS(LEN_NABTS), .LEN_WST60(LEN_WST60)
  ) u_proto (
    .clk(clk), .rst_n(rst_s), .line_num(line_num), .in_win_c(in_win_c),
    .bit_en(bit_en), .old_proto(old_proto), .ws60_sel(ws60_sel),
    .sys_525(sys_525), .req(req), .in_win(in_win)
  );

endmodule

// File: rtl/ttx_req_chk.sv
module ttx_req_chk #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              in_win,
  input logic              old_proto,
  input logic              bit_en,
  input logic [LINE_W-1:0] line_num
);

  AST_NEWPROTO_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !$past(old_proto)) |-> $past(bit_en)); // R6

  AST_NEWPROTO_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !$past(old_proto)) |-> in_win); // R5

  AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && old_proto && $stable(old_proto) && !bit_en && $stable(line_num)) |=> req); // R7

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!req && !in_win); // R9
    end
  end

endmodule

bind ttx_req_gen ttx_req_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .in_win(in_win),
  .old_proto(old_proto), .bit_en(bit_en), .line_num(line_num)
);

// File: tb/ttx_req_gen_tb.sv
module ttx_req_gen_tb_top;

  logic        clk;
  logic        rst_n;
  logic        strap_525;
  logic [9:0]  line_num;
  logic        field_even, sys_525, ws60_sel, old_proto, bit_en, cfg_load;
  logic [7:0]  odd_start_in, odd_end_in, even_start_in, even_end_in;
  logic [19:0] line_mask;
  logic        req, in_win;

  int n_chk;
  int n_fail;

  ttx_req_gen dut_i (
    .clk(clk), .rst_n(rst_n), .strap_525(strap_525), .line_num(line_num),
    .field_even(field_even), .sys_525(sys_525), .ws60_sel(ws60_sel),
    .old_proto(old_proto), .bit_en(bit_en), .cfg_load(cfg_load),
    .odd_start_in(odd_start_in), .odd_end_in(odd_end_in),
    .even_start_in(even_start_in), .even_end_in(even_end_in),
    .line_mask(line_mask), .req(req), .in_win(in_win)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_win(int line, int s, int e, int m525, int mask);
    int first = s + (m525 ? 4 : 1);
    int last  = e + (m525 ? 3 : 0);
    int hit   = 0;
    if (line >= 5 && line <= 24) hit = (mask >> (line - 5)) & 1;
    return (line >= first && line <= last && hit == 0) ? 1 : 0;
  endfunction

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    strap_525 = strap;
    repeat (2) @(negedge clk);
    chk("R9 reset req", req, 0);
    chk("R9 reset in_win", in_win, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sweep(input string tag, input int s, input int e, input int fe,
                       input int m525, input int mask);
    @(negedge clk);
    field_even = fe[0];
    sys_525 = m525[0];
    line_mask = mask[19:0];
    for (int ln = 0; ln <= 40; ln++) begin
      line_num = ln[9:0];
      @(negedge clk);
      chk(tag, in_win, exp_win(ln, s, e, m525, mask));
    end
  endtask

  task automatic load_cfg(input int os, input int oe, input int es, input int ee);
    @(negedge clk);
    odd_start_in = os[7:0];
    odd_end_in = oe[7:0];
    even_start_in = es[7:0];
    even_end_in = ee[7:0];
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic burst(input string tag, input int len, input int line);
    @(negedge clk);
    old_proto = 1'b1;
    bit_en = 1'b0;
    line_num = 10'd0;
    @(negedge clk);
    line_num = line[9:0];
    @(negedge clk);
    chk(tag, req, 1);
    for (int i = 0; i < len - 1; i++) begin
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      @(negedge clk);
    end
    chk(tag, req, 1);
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    @(negedge clk);
    chk(tag, req, 0);
  endtask

  task automatic single_bit(input string tag, input int line, input int exp);
    @(negedge clk);
    old_proto = 1'b0;
    bit_en = 1'b0;
    line_num = line[9:0];
    @(negedge clk);
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    chk(tag, req, exp);
    @(negedge clk);
    chk(tag, req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b1;
    strap_525 = 1'b0;
    line_num = '0;
    field_even = 1'b0;
    sys_525 = 1'b0;
    ws60_sel = 1'b0;
    old_proto = 1'b0;
    bit_en = 1'b0;
    cfg_load = 1'b0;
    odd_start_in = '0;
    odd_end_in = '0;
    even_start_in = '0;
    even_end_in = '0;
    line_mask = '0;

    // R3: defaults for the 525-line strap, both fields
    do_reset(1'b1);
    sweep("R3 strap525 sys525 odd", 5, 16, 0, 1, 0);
    sweep("R3 strap525 sys625 even", 5, 16, 1, 0, 0);

    // R3: defaults for the 625-line strap
    do_reset(1'b0);
    sweep("R3 strap625 odd", 4, 22, 0, 0, 0);
    sweep("R3 strap625 even", 4, 22, 1, 0, 0);

    // R6: bit-by-bit protocol, inside and outside the window (5..22)
    single_bit("R6 in window", 10, 1);
    single_bit("R6 outside window", 30, 0);

    // R7 / R8: burst lengths per standard
    ws60_sel = 1'b0;
    sys_525 = 1'b0;
    burst("R7 euro burst", 360, 10);
    @(negedge clk);
    sys_525 = 1'b1;
    burst("R8 nabts burst", 288, 12);
    @(negedge clk);
    ws60_sel = 1'b1;
    burst("R8 wst60 burst", 296, 12);
    @(negedge clk);
    ws60_sel = 1'b0;
    old_proto = 1'b0;

    // R4: loaded pairs, field select
    load_cfg(10, 30, 2, 8);
    sweep("R4 R2 odd sys625", 10, 30, 0, 0, 0);
    sweep("R4 R2 even sys625", 2, 8, 1, 0, 0);
    sweep("R1 odd sys525", 10, 30, 0, 1, 0);
    sweep("R1 even sys525", 2, 8, 1, 1, 0);

    // R5: mask lines 5, 10, 15, 24 (bits 0, 5, 10, 19)
    sweep("R5 mask odd", 10, 30, 0, 0, 32'h80421);
    sweep("R5 mask even", 2, 8, 1, 1, 32'h80421);
    load_cfg(0, 40, 0, 40);
    sweep("R5 mask wide", 0, 40, 0, 0, 32'hFFFFF);
    sweep("R2 wide window", 0, 40, 1, 0, 0);

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule